// File: doc/BRIEF.md
# Packed Multiply-Sum Accumulate Unit

This unit performs a dot product of four signed 16-bit lanes with a wide running sum. Each 64-bit source operand holds four 16-bit lanes. The unit multiplies each lane of the first source by the lane in the same position of the second source. It adds the four products together and then adds that total to a 64-bit accumulator operand. The sum is never rounded or saturated, so the full product precision always reaches the result. The result carries no fractional scaling.

The datapath is a three-stage pipeline: lane multiply, pair reduction, and final accumulate. It accepts one operation per clock. Both edges are valid/ready streams:
- An operation enters on a rising edge where `in_valid` and `in_ready` are both high.
- A result leaves on a rising edge where `out_valid` and `out_ready` are both high.
- Back-pressure is global. When a result sits at the output and is not taken, the whole pipeline freezes and `in_ready` drops. A source must hold its operation stable until the operation is accepted.
- Empty slots (bubbles) travel through the pipeline and are not squeezed out.

Top module: `msum_acc`

## Requirements
- R1: Lane k of each source occupies bits [16k+15:16k] and is read as a signed two's complement value. Lane k of `in_src_a` is multiplied only with lane k of `in_src_b`.
- R2: The result equals `in_acc` plus the sum of the four full 32-bit products. Each product is sign-extended to 64 bits, and the sum has no rounding and no saturation.
- R3: The final addition wraps modulo 2^64.
- R4: While `out_ready` is held high, an operation accepted on rising edge n appears with `out_valid` high after rising edge n+2. That is the third edge, counting the accepting edge as the first.
- R5: With `out_ready` high, operations presented on consecutive cycles are all accepted. Their results appear on consecutive cycles.
- R6: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. No operation is accepted while `in_ready` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R8: Results leave in acceptance order. No result is lost or repeated across a stall.
- R9: A synchronous active-low reset clears every in-flight operation. During reset and on the first cycle after it, `out_valid` is low and `in_ready` is high.
- R10: With `out_ready` high, a cycle in which no operation is accepted produces a cycle with `out_valid` low three cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit accepts an operation on this edge |
| in_src_a | input | 64 | First source, four signed 16-bit lanes |
| in_src_b | input | 64 | Second source, four signed 16-bit lanes |
| in_acc | input | 64 | Accumulator operand |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result on this edge |
| out_data | output | 64 | Accumulated dot-product result |

## Verification
The delicate cycle is the one where a stalled result is released and a waiting operation is accepted on the same edge. The bench stalls the output with three operations in flight and keeps a fourth operation offered. It then raises `out_ready` while that operation is still presented. The check is that the next three results emerge in order with the fourth operation inside them, and that no result is skipped or repeated. A second overlap occurs in the back-to-back stream, where a result leaves on every edge that also takes in a new operation. That stream is judged against hand-computed sums, including the most negative lane values and a wrapping accumulator.

// File: rtl/msum_pkg.sv
package msum_pkg;
  localparam int unsigned DEF_LANE_W = 16;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_ACC_W  = 64;
  localparam int unsigned PIPE_LAT   = 3;
endpackage

// File: rtl/msum_lane_mul.sv
module msum_lane_mul #(
  parameter int LANE_W = 16,
  localparam int PW = 2 * LANE_W
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [PW-1:0]     prod
);
  logic signed [PW-1:0] ax;
  logic signed [PW-1:0] bx;

  // sign-extend both lanes so the full-width product is exact
  assign ax   = {{LANE_W{a[LANE_W-1]}}, a};
  assign bx   = {{LANE_W{b[LANE_W-1]}}, b};
  assign prod = ax * bx;
endmodule

// File: rtl/msum_pair_add.sv
module msum_pair_add #(
  parameter int IN_W = 32
) (
  input  logic [IN_W-1:0] x,
  input  logic [IN_W-1:0] y,
  output logic [IN_W:0]   s
);
  // one guard bit keeps the signed pair sum exact
  assign s = {x[IN_W-1], x} + {y[IN_W-1], y};
endmodule

// File: rtl/msum_final_add.sv
module msum_final_add #(
  parameter int IN_W  = 33,
  parameter int N     = 2,
  parameter int ACC_W = 64
) (
  input  logic [IN_W-1:0]  part [N],
  input  logic [ACC_W-1:0] acc,
  output logic [ACC_W-1:0] sum
);
  always_comb begin
    sum = acc;
    for (int k = 0; k < N; k++) begin
      sum = sum + {{(ACC_W-IN_W){part[k][IN_W-1]}}, part[k]};
    end
  end
endmodule

// File: rtl/msum_acc.sv
module msum_acc #(
  parameter int LANE_W = msum_pkg::DEF_LANE_W,
  parameter int LANES  = msum_pkg::DEF_LANES,
  parameter int ACC_W  = msum_pkg::DEF_ACC_W,
  localparam int SRC_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SRC_W-1:0] in_src_a,
  input  logic [SRC_W-1:0] in_src_b,
  input  logic [ACC_W-1:0] in_acc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data
);
  localparam int PROD_W = 2 * LANE_W;
  localparam int PAIR_W = PROD_W + 1;
  localparam int PAIRS  = LANES / 2;

  logic advance;

  // stage 1: lane products
  logic [PROD_W-1:0] mul_out  [LANES];
  logic [PROD_W-1:0] s1_prod  [LANES];
  logic [ACC_W-1:0]  s1_acc;
  logic              s1_valid;

  // stage 2: pair sums
  logic [PAIR_W-1:0] pair_out [PAIRS];
  logic [PAIR_W-1:0] s2_pair  [PAIRS];
  logic [ACC_W-1:0]  s2_acc;
  logic              s2_valid;

  // stage 3: accumulate
  logic [ACC_W-1:0]  fin_sum;
  logic [ACC_W-1:0]  s3_data;
  logic              s3_valid;

  // the whole pipe moves unless a result is held at the output
  assign advance  = !s3_valid || out_ready;
  assign in_ready = advance;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    msum_lane_mul #(.LANE_W(LANE_W)) u_mul (
      .a    (in_src_a[l*LANE_W +: LANE_W]),
      .b    (in_src_b[l*LANE_W +: LANE_W]),
      .prod (mul_out[l])
    );
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    msum_pair_add #(.IN_W(PROD_W)) u_pair (
      .x (s1_prod[2*p]),
      .y (s1_prod[2*p+1]),
      .s (pair_out[p])
    );
  end

  msum_final_add #(.IN_W(PAIR_W), .N(PAIRS), .ACC_W(ACC_W)) u_fin (
    .part (s2_pair),
    .acc  (s2_acc),
    .sum  (fin_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else if (advance) begin
      s1_valid <= in_valid;
      s2_valid <= s1_valid;
      s3_valid <= s2_valid;
    end
  end

  // data registers need no reset; they only load on a valid slot
  always_ff @(posedge clk) begin
    if (advance && in_valid) begin
      s1_prod <= mul_out;
      s1_acc  <= in_acc;
    end
    if (advance && s1_valid) begin
      s2_pair <= pair_out;
      s2_acc  <= s1_acc;
    end
    if (advance && s2_valid) begin
      s3_data <= fin_sum;
    end
  end

  assign out_valid = s3_valid;
  assign out_data  = s3_data;
endmodule

// File: rtl/msum_acc_chk.sv
module msum_acc_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int ACC_W  = 64,
  localparam int SRC_W = LANE_W * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SRC_W-1:0] in_src_a,
  input logic [SRC_W-1:0] in_src_b,
  input logic [ACC_W-1:0] in_acc,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data
);
  function automatic logic [ACC_W-1:0] model(input logic [SRC_W-1:0] a,
                                             input logic [SRC_W-1:0] b,
                                             input logic [ACC_W-1:0] c);
    logic [ACC_W-1:0] r;
    logic signed [ACC_W-1:0] x;
    logic signed [ACC_W-1:0] y;
    r = c;
    for (int l = 0; l < LANES; l++) begin
      x = ACC_W'($signed(a[l*LANE_W +: LANE_W]));
      y = ACC_W'($signed(b[l*LANE_W +: LANE_W]));
      r = r + ACC_W'(x * y);
    end
    return r;
  endfunction

  logic [ACC_W-1:0] want_now;
  logic             take_now;
  assign want_now = model(in_src_a, in_src_b, in_acc);
  assign take_now = in_valid && in_ready;

  // R4 / R2: a result taken three unstalled cycles back shows up with its value
  p_latency_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) &&
     $past(take_now, 3) && $past(in_ready, 2) && $past(in_ready, 1))
    |-> (out_valid && out_data == $past(want_now, 3)));

  // R10: a bubble travels the same path
  p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) &&
     $past(in_ready, 3) && !$past(in_valid, 3) &&
     $past(in_ready, 2) && $past(in_ready, 1))
    |-> !out_valid);

  // R7: a held result does not move
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: a held result blocks intake
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: reset empties the output
  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind msum_acc msum_acc_chk #(.LANE_W(LANE_W), .LANES(LANES), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_src_a  (in_src_a),
  .in_src_b  (in_src_b),
  .in_acc    (in_acc),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_msum_acc.sv
`timescale 1ns/1ps
module sim_msum_acc;
  localparam int NV = 8;

  // R1 R2 R3 vectors: lane k at bits [16k+15:16k], signed
  localparam logic [63:0] VA [NV] = '{
    64'h0001_0002_0003_0004, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8000_8000_8000,
    64'h0000_0000_0000_0001, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF,
    64'h0000_0000_0000_0000, 64'h0003_FFFE_0000_0005};
  localparam logic [63:0] VB [NV] = '{
    64'h0005_0006_0007_0008, 64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000,
    64'h0000_0000_0000_0001, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000,
    64'h0000_0000_0000_0000, 64'h0004_0004_0009_FFFF};
  localparam logic [63:0] VC [NV] = '{
    64'h0, 64'h10, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0,
    64'h8000_0000_0000_0000, 64'h1};
  localparam logic [63:0] VE [NV] = '{
    64'h46, 64'hC, 64'h1_0000_0000, 64'h0, 64'hFFFC_0004,
    64'hFFFF_FFFF_0002_0000, 64'h8000_0000_0000_0000, 64'h0};

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic in_ready;
  logic [63:0] in_src_a;
  logic [63:0] in_src_b;
  logic [63:0] in_acc;
  logic out_valid;
  logic out_ready;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  msum_acc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int i);
    in_valid = 1'b1;
    in_src_a = VA[i];
    in_src_b = VB[i];
    in_acc   = VC[i];
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_src_a = '0; in_src_b = '0; in_acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset out_valid", 64'(out_valid), 64'd0);
    chk("R9 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // back-to-back stream: one vector per cycle, results three edges later
    for (int i = 0; i < NV + 3; i++) begin
      if (i >= 3) begin
        chk("R5 stream out_valid", 64'(out_valid), 64'd1);
        chk("R1 R2 R3 stream value", out_data, VE[i-3]);
      end else begin
        chk("R4 no early result", 64'(out_valid), 64'd0);
      end
      if (i < NV) put(i); else in_valid = 1'b0;
      @(negedge clk);
    end
    chk("R10 bubble after stream", 64'(out_valid), 64'd0);

    // single op latency
    put(2);
    @(negedge clk); in_valid = 1'b0;
    chk("R4 latency edge1", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R4 latency edge2", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R4 latency edge3 valid", 64'(out_valid), 64'd1);
    chk("R4 latency edge3 value", out_data, VE[2]);
    @(negedge clk);
    chk("R10 single op bubble", 64'(out_valid), 64'd0);

    // stall: three in flight, fourth waiting, then release
    out_ready = 1'b0;
    put(0); @(negedge clk);
    put(1); @(negedge clk);
    put(5); @(negedge clk);
    chk("R6 stall in_ready low", 64'(in_ready), 64'd0);
    chk("R7 stall value", out_data, VE[0]);
    put(7);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 held valid", 64'(out_valid), 64'd1);
      chk("R7 held value", out_data, VE[0]);
      chk("R6 held in_ready", 64'(in_ready), 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 release first", out_data, VE[1]);
    @(negedge clk);
    chk("R8 release second", out_data, VE[5]);
    @(negedge clk);
    chk("R8 waiting op value", out_data, VE[7]);
    chk("R8 waiting op valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R8 no duplicate", 64'(out_valid), 64'd0);

    // reset with operations in flight
    put(3); @(negedge clk);
    put(4); @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R9 flushed", 64'(out_valid), 64'd0);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule